// File: doc/BRIEF.md
# Receive Frame Page Writer

This block takes a received frame as a byte stream and stores it into one fixed-size packet page of the controller's buffer memory. The frame length arrives with the first beat. The block uses that length to decide whether the frame can be taken at all. If it can, the block asks the page allocator for a page. It then writes the page in the layout that software parses: a little-endian status word, a little-endian stored byte count, the frame data, an optional CRC-32 and a two-byte trailer that ends in a control code.

A frame can be refused for three reasons: receive is switched off, the soft-reset control is set, or the frame's stored size would not fit in a page. It is also dropped when the allocator answers that no page is free. A refused or dropped frame is still drained from the stream so the source never stalls. When the control byte of an accepted frame has been written, a one-cycle done pulse carries the page number. The receive queue uses this pulse to enqueue the page and raise its interrupt, so software never sees a half-written page.

Top module: `rxw_writer`

## Requirements
- R1: When `rx_enable` is 0 or `soft_reset` is 1 in the cycle a first beat is presented while idle, the frame is refused. All of its beats are consumed, `page_req` never rises, nothing is written and `done` stays low.
- R2: When the allocator answers a request with `page_none` (and no `page_gnt`), all beats of the frame are consumed, nothing is written and `done` stays low.
- R3: The stored count is E + 6, plus 4 when CRC is kept (`strip_crc` = 0). E is the frame length rounded down to even, or 64 when the length is below 64. The count is written low byte at page address 2 and high byte at address 3.
- R4: A frame whose stored count would exceed the page size (2048 bytes) is refused exactly as in R1, without a page request.
- R5: Page addresses 0 (low) and 1 (high) hold the status word. Bit 11 is set when the length exceeds 1518 and bit 12 is set when the length is odd. All other bits are 0.
- R6: Frame bytes are stored in arrival order from page address 4. An accepted frame produces exactly as many byte writes as its stored count, all to the granted page.
- R7: A frame shorter than 64 bytes has all of its bytes stored in place, including an odd final byte, followed by zero bytes up to data offset 64. Its trailer is 0x00 then control 0x40.
- R8: When CRC is kept, 4 CRC bytes follow the E data bytes, least significant byte first. The CRC uses the reflected polynomial 0xEDB88320 with an all-ones preset and a final inversion. It covers every frame byte and every pad byte. When CRC is stripped, no CRC bytes are stored.
- R9: For an odd frame of 64 bytes or more, the final frame byte is not stored in the data area. It is stored after the CRC (or after the data when CRC is stripped), followed by control 0x60. An even frame ends with 0x00 then control 0x40.
- R10: `done` is a one-cycle pulse. It is raised in the cycle right after the control byte write, with `done_page` equal to the granted page.
- R11: `page_req` is raised the cycle after an admitted first beat. It stays high until `page_gnt` or `page_none` arrives, and a grant takes priority. No memory write occurs while `page_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Receive switched on |
| soft_reset | input | 1 | Soft-reset control; refuses frames while set |
| strip_crc | input | 1 | 1: do not store the CRC |
| in_valid | input | 1 | Stream beat valid |
| in_first | input | 1 | Beat is the first of a frame |
| in_last | input | 1 | Beat is the last of a frame |
| in_len | input | LEN_W | Frame length in bytes, valid with the first beat |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Beat accepted on this edge when valid |
| page_req | output | 1 | Request for a free page |
| page_gnt | input | 1 | Allocator grants a page |
| page_none | input | 1 | Allocator has no free page |
| page_id | input | PAGE_ID_W | Granted page number |
| mem_we | output | 1 | Page memory byte write strobe |
| mem_page | output | PAGE_ID_W | Page being written |
| mem_addr | output | ADDR_W | Byte address within the page |
| mem_wdata | output | 8 | Byte written |
| done | output | 1 | Page complete pulse |
| done_page | output | PAGE_ID_W | Page number completed |

## Verification
The assertions take for granted that the allocator raises `page_gnt` or `page_none` only while `page_req` is high, and only for a single cycle. They also assume that `in_len` is at least 1 and matches the number of beats up to `in_last`. The bench's allocator model answers only in a cycle where it sees the request high, and drops its answer in the next cycle. Every frame is driven with `in_last` on exactly its `in_len`-th beat and `in_first` only before the first beat is taken. Frame lengths run through every value from 1 to 70 in both CRC modes, plus the lengths around 1518 and around the page-size limit.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

    localparam logic [31:0] CRC_POLY  = 32'hEDB88320;
    localparam logic [31:0] CRC_PRESET = 32'hFFFFFFFF;
    localparam logic [7:0]  CTRL_ODD  = 8'h60;
    localparam logic [7:0]  CTRL_EVEN = 8'h40;
    localparam int          HDR_BYTES = 4;
    localparam int          CRC_BYTES = 4;
    localparam int          FIXED_OVERHEAD = 6;
    localparam int          STAT_LONG_BIT = 11;
    localparam int          STAT_ODD_BIT  = 12;
    localparam logic [3:0]  STEP_HDR  = 4'd4;
    localparam logic [3:0]  STEP_LAST = 4'd9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_DATA,
        ST_DROP,
        ST_PAD,
        ST_TAIL,
        ST_DONE
    } rxw_state_e;

    typedef struct packed {
        logic [15:0] body;      // data bytes occupying the data area (E)
        logic [15:0] count;     // stored byte count
        logic [15:0] status;    // status word
        logic        odd_tail;  // final byte moves behind the CRC
        logic        fits;      // stored count within a page
    } rxw_layout_t;

    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'd0, b};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rxw_layout.sv
module rxw_layout
    import rxw_pkg::*;
#(
    parameter int LEN_W      = 12,
    parameter int MIN_FRAME  = 64,
    parameter int LONG_LIMIT = 1518,
    parameter int PAGE_BYTES = 2048
) (
    input  logic [LEN_W-1:0] len,
    input  logic             keep_crc,
    output rxw_layout_t      lay
);
    logic [15:0] len16;
    logic [15:0] even16;

    always_comb begin
        len16  = 16'(len);
        even16 = {len16[15:1], 1'b0};
        lay.body  = (len16 < 16'(MIN_FRAME)) ? 16'(MIN_FRAME) : even16;
        lay.count = lay.body + 16'(FIXED_OVERHEAD) + (keep_crc ? 16'(CRC_BYTES) : 16'd0);
        lay.fits  = (lay.count <= 16'(PAGE_BYTES));
        lay.status = '0;
        lay.status[STAT_LONG_BIT] = (len16 > 16'(LONG_LIMIT));
        lay.status[STAT_ODD_BIT]  = len16[0];
        lay.odd_tail = len16[0] && (len16 >= 16'(MIN_FRAME));
    end
endmodule

// File: rtl/rxw_crc.sv
module rxw_crc
    import rxw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc_out
);
    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || init) begin
            crc_q <= CRC_PRESET;
        end else if (en) begin
            crc_q <= crc32_step(crc_q, din);
        end
    end

    assign crc_out = ~crc_q;
endmodule

// File: rtl/rxw_ctrl.sv
module rxw_ctrl
    import rxw_pkg::*;
#(
    parameter int LEN_W     = 12,
    parameter int MIN_FRAME = 64,
    parameter int PAGE_ID_W = 2,
    parameter int ADDR_W    = 11
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_enable,
    input  logic                 soft_reset,
    input  logic                 strip_crc,
    input  logic                 in_valid,
    input  logic                 in_first,
    input  logic                 in_last,
    input  logic [LEN_W-1:0]     in_len,
    input  logic [7:0]           in_data,
    output logic                 in_ready,
    output logic                 page_req,
    input  logic                 page_gnt,
    input  logic                 page_none,
    input  logic [PAGE_ID_W-1:0] page_id,
    output logic [LEN_W-1:0]     lay_len,
    output logic                 lay_keep,
    input  rxw_layout_t          lay,
    output logic                 crc_init,
    output logic                 crc_en,
    output logic [7:0]           crc_din,
    input  logic [31:0]          crc_val,
    output logic                 mem_we,
    output logic [PAGE_ID_W-1:0] mem_page,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [7:0]           mem_wdata,
    output logic                 done,
    output logic [PAGE_ID_W-1:0] done_page
);
    rxw_state_e             state;
    logic [LEN_W-1:0]       len_q;
    logic [LEN_W-1:0]       idx;
    logic                   keep_q;
    logic [PAGE_ID_W-1:0]   page_q;
    logic [7:0]             held_q;
    logic [3:0]             step_q;

    logic                   start;
    logic                   refuse;
    logic                   accept;
    logic                   is_held;
    logic [ADDR_W-1:0]      tail_base;
    logic [3:0]             tail_first;

    assign lay_len  = (state == ST_IDLE) ? in_len : len_q;
    assign lay_keep = (state == ST_IDLE) ? ~strip_crc : keep_q;

    assign start   = (state == ST_IDLE) && in_valid && in_first;
    assign refuse  = !rx_enable || soft_reset || !lay.fits;
    assign accept  = in_valid && in_ready;
    assign is_held = lay.odd_tail && (idx == len_q - 1'b1);
    assign tail_base  = ADDR_W'(HDR_BYTES) + ADDR_W'(lay.body);
    assign tail_first = keep_q ? 4'd0 : STEP_HDR;

    assign mem_page  = page_q;
    assign done_page = page_q;

    always_comb begin
        in_ready  = 1'b0;
        page_req  = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        crc_init  = (state == ST_IDLE);
        crc_en    = 1'b0;
        crc_din   = in_data;
        done      = 1'b0;
        case (state)
            ST_REQ: page_req = 1'b1;
            ST_DROP: in_ready = 1'b1;
            ST_DATA: begin
                in_ready  = 1'b1;
                crc_en    = in_valid;
                mem_we    = in_valid && !is_held;
                mem_addr  = ADDR_W'(HDR_BYTES) + ADDR_W'(idx);
                mem_wdata = in_data;
            end
            ST_PAD: begin
                crc_en    = 1'b1;
                crc_din   = 8'h00;
                mem_we    = 1'b1;
                mem_addr  = ADDR_W'(HDR_BYTES) + ADDR_W'(idx);
                mem_wdata = 8'h00;
            end
            ST_TAIL: begin
                mem_we = 1'b1;
                case (step_q)
                    4'd0: begin mem_addr = tail_base;           mem_wdata = crc_val[7:0];   end
                    4'd1: begin mem_addr = tail_base + 1'b1;    mem_wdata = crc_val[15:8];  end
                    4'd2: begin mem_addr = tail_base + 2'd2;    mem_wdata = crc_val[23:16]; end
                    4'd3: begin mem_addr = tail_base + 2'd3;    mem_wdata = crc_val[31:24]; end
                    4'd4: begin mem_addr = ADDR_W'(0);          mem_wdata = lay.status[7:0];  end
                    4'd5: begin mem_addr = ADDR_W'(1);          mem_wdata = lay.status[15:8]; end
                    4'd6: begin mem_addr = ADDR_W'(2);          mem_wdata = lay.count[7:0];   end
                    4'd7: begin mem_addr = ADDR_W'(3);          mem_wdata = lay.count[15:8];  end
                    4'd8: begin
                        mem_addr  = tail_base + (keep_q ? ADDR_W'(CRC_BYTES) : ADDR_W'(0));
                        mem_wdata = lay.odd_tail ? held_q : 8'h00;
                    end
                    default: begin
                        mem_addr  = tail_base + (keep_q ? ADDR_W'(CRC_BYTES + 1) : ADDR_W'(1));
                        mem_wdata = lay.odd_tail ? CTRL_ODD : CTRL_EVEN;
                    end
                endcase
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            len_q  <= '0;
            idx    <= '0;
            keep_q <= 1'b0;
            page_q <= '0;
            held_q <= '0;
            step_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        len_q  <= in_len;
                        keep_q <= ~strip_crc;
                        idx    <= '0;
                        state  <= refuse ? ST_DROP : ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (page_gnt) begin
                        page_q <= page_id;
                        state  <= ST_DATA;
                    end else if (page_none) begin
                        state  <= ST_DROP;
                    end
                end
                ST_DATA: begin
                    if (accept) begin
                        idx <= idx + 1'b1;
                        if (is_held) held_q <= in_data;
                        if (in_last) begin
                            step_q <= tail_first;
                            state  <= (len_q < LEN_W'(MIN_FRAME)) ? ST_PAD : ST_TAIL;
                        end
                    end
                end
                ST_PAD: begin
                    idx <= idx + 1'b1;
                    if (idx == LEN_W'(MIN_FRAME - 1)) state <= ST_TAIL;
                end
                ST_TAIL: begin
                    step_q <= step_q + 1'b1;
                    if (step_q == STEP_LAST) state <= ST_DONE;
                end
                ST_DONE: state <= ST_IDLE;
                ST_DROP: begin
                    if (accept && in_last) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rxw_writer.sv
module rxw_writer
    import rxw_pkg::*;
#(
    parameter int LEN_W      = 12,
    parameter int PAGE_BYTES = 2048,
    parameter int PAGE_ID_W  = 2,
    parameter int MIN_FRAME  = 64,
    parameter int LONG_LIMIT = 1518,
    localparam int ADDR_W    = $clog2(PAGE_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_enable,
    input  logic                 soft_reset,
    input  logic                 strip_crc,
    input  logic                 in_valid,
    input  logic                 in_first,
    input  logic                 in_last,
    input  logic [LEN_W-1:0]     in_len,
    input  logic [7:0]           in_data,
    output logic                 in_ready,
    output logic                 page_req,
    input  logic                 page_gnt,
    input  logic                 page_none,
    input  logic [PAGE_ID_W-1:0] page_id,
    output logic                 mem_we,
    output logic [PAGE_ID_W-1:0] mem_page,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [7:0]           mem_wdata,
    output logic                 done,
    output logic [PAGE_ID_W-1:0] done_page
);
    logic [LEN_W-1:0] lay_len;
    logic             lay_keep;
    rxw_layout_t      lay;
    logic             crc_init;
    logic             crc_en;
    logic [7:0]       crc_din;
    logic [31:0]      crc_val;

    rxw_layout #(
        .LEN_W(LEN_W), .MIN_FRAME(MIN_FRAME),
        .LONG_LIMIT(LONG_LIMIT), .PAGE_BYTES(PAGE_BYTES)
    ) u_layout (
        .len(lay_len), .keep_crc(lay_keep), .lay(lay)
    );

    rxw_crc u_crc (
        .clk(clk), .rst(rst), .init(crc_init), .en(crc_en),
        .din(crc_din), .crc_out(crc_val)
    );

    rxw_ctrl #(
        .LEN_W(LEN_W), .MIN_FRAME(MIN_FRAME),
        .PAGE_ID_W(PAGE_ID_W), .ADDR_W(ADDR_W)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .rx_enable(rx_enable), .soft_reset(soft_reset), .strip_crc(strip_crc),
        .in_valid(in_valid), .in_first(in_first), .in_last(in_last),
        .in_len(in_len), .in_data(in_data), .in_ready(in_ready),
        .page_req(page_req), .page_gnt(page_gnt), .page_none(page_none),
        .page_id(page_id),
        .lay_len(lay_len), .lay_keep(lay_keep), .lay(lay),
        .crc_init(crc_init), .crc_en(crc_en), .crc_din(crc_din), .crc_val(crc_val),
        .mem_we(mem_we), .mem_page(mem_page), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .done(done), .done_page(done_page)
    );
endmodule

// File: rtl/rxw_checker.sv
module rxw_checker #(
    parameter int PAGE_ID_W = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 rx_enable,
    input logic                 soft_reset,
    input logic                 page_req,
    input logic                 page_gnt,
    input logic                 page_none,
    input logic                 mem_we,
    input logic [PAGE_ID_W-1:0] mem_page,
    input logic [7:0]           mem_wdata,
    input logic                 done
);
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_done_after_ctrl: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(mem_we) && ($past(mem_wdata) == 8'h40 || $past(mem_wdata) == 8'h60)));

    a_r1_req_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(page_req) |-> $past(rx_enable && !soft_reset));

    a_r11_req_ends_on_answer: assert property (@(posedge clk) disable iff (rst)
        (page_req && (page_gnt || page_none)) |=> !page_req);

    a_r11_no_write_while_req: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !page_req);

    a_r6_page_stable: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_page == $past(mem_page)));

    a_r10_no_write_on_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_we);
endmodule

bind rxw_writer rxw_checker #(.PAGE_ID_W(PAGE_ID_W)) u_rxw_checker (
    .clk(clk), .rst(rst), .rx_enable(rx_enable), .soft_reset(soft_reset),
    .page_req(page_req), .page_gnt(page_gnt), .page_none(page_none),
    .mem_we(mem_we), .mem_page(mem_page), .mem_wdata(mem_wdata), .done(done)
);

// File: tb/tb_rxw_writer.sv
module tb_rxw_writer;
    localparam int LEN_W = 12;
    localparam int PAGE_ID_W = 2;
    localparam int ADDR_W = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_enable = 1'b1, soft_reset = 1'b0, strip_crc = 1'b0;
    logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
    logic [LEN_W-1:0] in_len = '0;
    logic [7:0] in_data = '0;
    logic in_ready, page_req, mem_we, done;
    logic page_gnt = 1'b0, page_none = 1'b0;
    logic [PAGE_ID_W-1:0] page_id = '0;
    logic [PAGE_ID_W-1:0] mem_page, done_page;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0] mem_wdata;

    always #5 clk = ~clk;

    rxw_writer dut (
        .clk(clk), .rst(rst), .rx_enable(rx_enable), .soft_reset(soft_reset),
        .strip_crc(strip_crc), .in_valid(in_valid), .in_first(in_first),
        .in_last(in_last), .in_len(in_len), .in_data(in_data), .in_ready(in_ready),
        .page_req(page_req), .page_gnt(page_gnt), .page_none(page_none),
        .page_id(page_id), .mem_we(mem_we), .mem_page(mem_page),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done), .done_page(done_page)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] bmem [0:2047];
    logic [7:0] exp_m [0:2047];
    int exp_cnt;
    int wr_cnt;
    int bad_page;
    int cur_pid;
    bit req_seen;

    always @(posedge clk) begin
        if (mem_we) begin
            bmem[mem_addr] = mem_wdata;
            wr_cnt++;
            if (int'(mem_page) != cur_pid) bad_page++;
        end
        if (page_req) req_seen = 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic logic [7:0] pat(input int j, input int seed);
        return 8'(j * 7 + seed);
    endfunction

    function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'd0, b};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        return r;
    endfunction

    task automatic build_exp(input int len, input int seed, input bit keep);
        int e; int p; int st; int lim; logic [31:0] c; logic [7:0] b;
        e = (len < 64) ? 64 : (len & ~1);
        exp_cnt = e + 6 + (keep ? 4 : 0);
        for (int a = 0; a < 2048; a++) exp_m[a] = 8'h00;
        st = ((len > 1518) ? 32'h0800 : 0) | ((len % 2 == 1) ? 32'h1000 : 0);
        exp_m[0] = 8'(st); exp_m[1] = 8'(st >> 8);
        exp_m[2] = 8'(exp_cnt); exp_m[3] = 8'(exp_cnt >> 8);
        c = 32'hFFFFFFFF;
        lim = (len > e) ? len : e;
        for (int j = 0; j < lim; j++) begin
            b = (j < len) ? pat(j, seed) : 8'h00;
            if (j < e) exp_m[4 + j] = b;
            c = crc_upd(c, b);
        end
        c = ~c;
        p = 4 + e;
        if (keep) begin
            for (int k = 0; k < 4; k++) exp_m[p + k] = 8'(c >> (8 * k));
            p = p + 4;
        end
        if ((len % 2 == 1) && len >= 64) begin
            exp_m[p] = pat(len - 1, seed); exp_m[p + 1] = 8'h60;
        end else begin
            exp_m[p] = 8'h00; exp_m[p + 1] = 8'h40;
        end
    endtask

    task automatic run_frame(input int len, input bit keep, input int seed,
                             input bit acc, input bit aok, input bit expect_req,
                             input int pid, input string tag);
        int i; int cyc; bit ok; bit got; int dp; int bad_at;
        build_exp(len, seed, keep);
        for (int a = 0; a < 2048; a++) bmem[a] = 8'hEE;
        wr_cnt = 0; bad_page = 0; req_seen = 1'b0; cur_pid = pid;
        strip_crc = !keep;
        i = 0; cyc = 0;
        while (i < len && cyc < 5000) begin
            @(negedge clk);
            page_gnt  = page_req && aok;
            page_none = page_req && !aok;
            page_id   = PAGE_ID_W'(pid);
            in_valid  = 1'b1;
            in_first  = (i == 0);
            in_last   = (i == len - 1);
            in_len    = LEN_W'(len);
            in_data   = pat(i, seed);
            ok = in_ready;
            @(posedge clk);
            if (ok) i++;
            cyc++;
        end
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
        page_gnt = 1'b0; page_none = 1'b0;
        got = 1'b0; dp = 0;
        for (int k = 0; k < 120 && !got; k++) begin
            if (done) begin got = 1'b1; dp = int'(done_page); end
            else @(negedge clk);
        end
        chk(i == len, tag, i, len);
        if (acc) begin
            chk(got, "R10", got, 1);
            chk(dp == pid, "R11", dp, pid);
            @(negedge clk);
            chk(!done, "R10", done, 0);
            chk(wr_cnt == exp_cnt && bad_page == 0, "R6", wr_cnt, exp_cnt);
            chk(bmem[0] == exp_m[0] && bmem[1] == exp_m[1], "R5",
                {bmem[1], bmem[0]}, {exp_m[1], exp_m[0]});
            chk(bmem[2] == exp_m[2] && bmem[3] == exp_m[3], "R3",
                {bmem[3], bmem[2]}, {exp_m[3], exp_m[2]});
            bad_at = -1;
            for (int a = 4; a < exp_cnt; a++)
                if (bad_at < 0 && bmem[a] !== exp_m[a]) bad_at = a;
            if (bad_at < 0) chk(1'b1, tag, 0, 0);
            else chk(1'b0, tag, bmem[bad_at], exp_m[bad_at]);
        end else begin
            chk(!got, tag, got, 0);
            chk(wr_cnt == 0, tag, wr_cnt, 0);
            chk(req_seen == expect_req, tag, req_seen, expect_req);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        chk(!in_ready && !page_req && !mem_we && !done, "R11",
            {in_ready, page_req, mem_we, done}, 0);

        // short, even and odd frames in both CRC modes (R7, R8, R9)
        for (int len = 1; len <= 70; len++) begin
            run_frame(len, 1'b0, len * 3, 1'b1, 1'b1, 1'b1, len % 4,
                      (len < 64) ? "R7" : "R9");
            run_frame(len, 1'b1, len * 5 + 1, 1'b1, 1'b1, 1'b1, (len + 1) % 4, "R8");
        end

        // long-frame status boundary (R5)
        for (int len = 1517; len <= 1520; len++)
            run_frame(len, 1'b1, len, 1'b1, 1'b1, 1'b1, len % 4, "R5");

        // page-size limit (R4)
        run_frame(2038, 1'b1, 9, 1'b1, 1'b1, 1'b1, 1, "R4");
        run_frame(2039, 1'b1, 8, 1'b1, 1'b1, 1'b1, 2, "R4");
        run_frame(2040, 1'b1, 7, 1'b0, 1'b1, 1'b0, 3, "R4");
        run_frame(2040, 1'b0, 6, 1'b1, 1'b1, 1'b1, 0, "R4");
        run_frame(2042, 1'b0, 5, 1'b1, 1'b1, 1'b1, 1, "R4");
        run_frame(2044, 1'b0, 4, 1'b0, 1'b1, 1'b0, 2, "R4");

        // receive disabled and soft reset (R1)
        rx_enable = 1'b0;
        run_frame(80, 1'b1, 3, 1'b0, 1'b1, 1'b0, 0, "R1");
        rx_enable = 1'b1; soft_reset = 1'b1;
        run_frame(81, 1'b1, 3, 1'b0, 1'b1, 1'b0, 0, "R1");
        soft_reset = 1'b0;

        // allocator has no page (R2)
        run_frame(90, 1'b1, 11, 1'b0, 1'b0, 1'b1, 0, "R2");
        run_frame(91, 1'b1, 12, 1'b1, 1'b1, 1'b1, 3, "R2");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule